// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block collects up to 64 interrupt inputs and presents one request line to a processor. Every source has an enable (mask) bit and a pending bit. Software sees these bits through two 32-bit mask registers and two 32-bit pending registers, a "high" and a "low" one. Source numbers do not map onto register bits by arithmetic. A fixed, irregular table picks the register and the bit for each source.

Each source takes a 2-bit sense code. The code selects active-low level, active-high level, falling-edge or rising-edge detection. Detection works on a synchronized copy of the input. Pending bits are cleared by writing ones. A read-only vector register reports the lowest-numbered unmasked pending source in its top six bits, and a zero there means nothing is active.

Software programs it over a plain 32-bit word-addressed bus with separate read and write strobes. Read data is registered.

Top module: `sic64_ctrl`

## Requirements
- R1: After reset all mask bits, pending bits and sense codes are zero, `irq_o` is low, and every readable register returns zero while all inputs are held high.
- R2: High-register mapping: source 0 uses bit 0, sources 1..15 use bit 16−n, and sources 32..47 use bit 63−n.
- R3: Low-register mapping: sources 16, 17 and 18 use bits 2, 1 and 0. Sources 19..30 use bit 33−n. Source 31 also uses bit 0, which it shares with source 18. Sources 48..63 use bit n−32.
- R4: Mask words sit at word address 0 (high) and 1 (low) and read back exactly as written, unused bits included. A mask bit of 1 lets its pending source drive `irq_o`. A 0 blocks it, but its pending bit is still set and readable.
- R5: Pending words sit at word address 2 (high) and 3 (low). Writing a 1 clears every pending bit mapped to that position, and writing a 0 changes nothing. Writing all ones clears every edge-detected request.
- R6: Word address 4 is the read-only vector register. Bits 31:26 hold the reported source and bits 25:0 read as zero. `irq_o` is high exactly when that field is nonzero.
- R7: When several unmasked sources are pending, the reported source is the lowest-numbered one above zero.
- R8: Sense codes sit at word addresses 5..8. Source n uses bits 2·(n mod 16)+1 : 2·(n mod 16) of word 5 + n/16, and these words read back as written. The codes are: 0 active-low level, 1 active-high level, 2 falling edge, 3 rising edge.
- R9: A level-sensed source sets its pending bit in every cycle its synchronized input is at the active level. A clear is overridden while the level persists. Once the input leaves that level, the bit stays set until it is cleared.
- R10: An edge-sensed source sets its pending bit only on the selected transition. The opposite transition has no effect, and the bit stays set until cleared.
- R11: Source 0 is reserved: its input never sets a pending bit, so it never raises `irq_o`.
- R12: Read data appears on `rdata` one cycle after `rd_en`. Unmapped word addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_i | input | 64 | Asynchronous interrupt inputs, one per source |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the bus never asserts `wr_en` and `rd_en` in the same cycle, and that the strobes and `src_i` carry known values from the first clock on. The stimulus drives all inputs only from tasks, one strobe at a time, starting from defined levels at time zero. Interrupt inputs rest high, so the default active-low level sense stays quiet. Edge pulses last several cycles, which is longer than the synchronizer chain, so no transition is lost.

// File: rtl/sic64_pkg.sv
package sic64_pkg;
  localparam int NSRC = 64;
  localparam int VW   = 6;
  localparam int DW   = 32;

  // word addresses
  localparam int A_MASK_HI = 0;
  localparam int A_MASK_LO = 1;
  localparam int A_PEND_HI = 2;
  localparam int A_PEND_LO = 3;
  localparam int A_VEC     = 4;
  localparam int A_SNS0    = 5;

  typedef enum logic [1:0] {
    SNS_LVL_LO = 2'd0,
    SNS_LVL_HI = 2'd1,
    SNS_FALL   = 2'd2,
    SNS_RISE   = 2'd3
  } sense_e;

  // 1 selects the high register pair, 0 the low pair
  function automatic logic map_is_hi(input int v);
    return (v < 16) || (v >= 32 && v < 48);
  endfunction

  // bit position of source v inside its register
  function automatic logic [4:0] map_bit(input int v);
    if (v == 0)       return 5'd0;
    else if (v < 16)  return 5'(16 - v);
    else if (v < 19)  return 5'(18 - v);
    else if (v < 31)  return 5'(33 - v);
    else if (v == 31) return 5'd0;
    else if (v < 48)  return 5'(63 - v);
    else              return 5'(v - 32);
  endfunction
endpackage

// File: rtl/sic64_sense.sv
module sic64_sense #(
  parameter int N      = 64,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   src_i,
  input  logic [2*N-1:0] sense,
  output logic [N-1:0]   hit
);
  import sic64_pkg::*;

  logic [STAGES-1:0][N-1:0] sync_q;
  logic [N-1:0]             prev_q;
  logic [N-1:0]             cur;

  assign cur = sync_q[STAGES-1];

  // inputs idle high, so the chain resets to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      sync_q[0] <= src_i;
      for (int k = 1; k < STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= cur;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    always_comb begin
      case (sense_e'(sense[2*i +: 2]))
        SNS_LVL_LO: hit[i] = ~cur[i];
        SNS_LVL_HI: hit[i] = cur[i];
        SNS_FALL:   hit[i] = prev_q[i] & ~cur[i];
        default:    hit[i] = ~prev_q[i] & cur[i];
      endcase
    end
  end
endmodule

// File: rtl/sic64_prio.sv
module sic64_prio #(
  parameter int N  = 64,
  parameter int VW = 6
) (
  input  logic [N-1:0]  act,
  output logic [VW-1:0] vec,
  output logic          any
);
  // scan downward so the lowest nonzero index wins
  always_comb begin
    vec = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (act[i]) vec = VW'(i);
    end
  end

  assign any = |act;
endmodule

// File: rtl/sic64_ctrl.sv
module sic64_ctrl
  import sic64_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o
);
  localparam int SNS_PER_WORD = DW / 2;
  localparam int SNS_WORDS    = NSRC / SNS_PER_WORD;

  logic [1:0][DW-1:0]   mask_q;
  logic [2*NSRC-1:0]    sense_q;
  logic [NSRC-1:0]      pend_q;
  logic [NSRC-1:0]      hit, hit_eff, clr, mask_vec, act;
  logic [1:0][DW-1:0]   pend_view;
  logic [VW-1:0]        vec_n, vec_q;
  logic                 any_n;
  logic [DW-1:0]        rd_mux;

  sic64_sense #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .src_i(src_i), .sense(sense_q), .hit(hit)
  );

  assign hit_eff = {hit[NSRC-1:1], 1'b0};

  // per-source view of mask and clear strobes through the fixed table
  always_comb begin
    for (int v = 0; v < NSRC; v++) begin
      mask_vec[v] = mask_q[map_is_hi(v)][map_bit(v)];
      clr[v] = wr_en && wdata[map_bit(v)] &&
               (map_is_hi(v) ? (addr == ADDR_W'(A_PEND_HI))
                             : (addr == ADDR_W'(A_PEND_LO)));
    end
  end

  // register view of pending bits: shared positions are ORed
  always_comb begin
    pend_view = '0;
    for (int v = 0; v < NSRC; v++)
      pend_view[map_is_hi(v)][map_bit(v)] = pend_view[map_is_hi(v)][map_bit(v)] | pend_q[v];
  end

  assign act = pend_q & mask_vec;

  sic64_prio #(.N(NSRC), .VW(VW)) u_prio (
    .act(act), .vec(vec_n), .any(any_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      sense_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_MASK_HI)) mask_q[1] <= wdata;
      if (addr == ADDR_W'(A_MASK_LO)) mask_q[0] <= wdata;
      for (int k = 0; k < SNS_WORDS; k++)
        if (addr == ADDR_W'(A_SNS0 + k)) sense_q[k*DW +: DW] <= wdata;
    end
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | hit_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '0;
      irq_o <= 1'b0;
    end else begin
      vec_q <= vec_n;
      irq_o <= any_n;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_MASK_HI)) rd_mux = mask_q[1];
    if (addr == ADDR_W'(A_MASK_LO)) rd_mux = mask_q[0];
    if (addr == ADDR_W'(A_PEND_HI)) rd_mux = pend_view[1];
    if (addr == ADDR_W'(A_PEND_LO)) rd_mux = pend_view[0];
    if (addr == ADDR_W'(A_VEC))     rd_mux = {vec_q, {(DW-VW){1'b0}}};
    for (int k = 0; k < SNS_WORDS; k++)
      if (addr == ADDR_W'(A_SNS0 + k)) rd_mux = sense_q[k*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/sic64_chk.sv
module sic64_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [63:0]       act,
  input logic [63:0]       pend,
  input logic [5:0]        vec_q,
  input logic              irq_o,
  input logic [1:0][31:0]  mask_q,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata
);
  logic [63:0] act_d;
  logic [63:0] below;

  always_ff @(posedge clk) begin
    if (rst) act_d <= '0;
    else     act_d <= act;
  end

  assign below = ((64'd1 << vec_q) - 64'd1) & ~64'd1;

  p_vec_active_r7: assert property (@(posedge clk) disable iff (rst)
    (vec_q != 6'd0) |-> act_d[vec_q]);

  p_vec_lowest_r7: assert property (@(posedge clk) disable iff (rst)
    (vec_q != 6'd0) |-> ((act_d & below) == 64'd0));

  p_irq_matches_vec_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o == (vec_q != 6'd0));

  p_all_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_o);

  p_src0_never_pends_r11: assert property (@(posedge clk) disable iff (rst)
    !pend[0]);

  p_vec_low_bits_zero_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == ADDR_W'(4)) |-> (rdata[25:0] == 26'd0));
endmodule

bind sic64_ctrl sic64_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .act(act), .pend(pend_q), .vec_q(vec_q),
  .irq_o(irq_o), .mask_q(mask_q), .rd_en(rd_en), .addr(addr), .rdata(rdata)
);

// File: tb/sic64_ctrl_tb_top.sv
`timescale 1ns/1ps
module sic64_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src_i = '1;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sic64_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_i(src_i), .irq_o(irq_o)
  );

  // source[11:6], high-pair flag[5], bit[4:0]
  localparam logic [11:0] MAP_TBL [11] = '{
    {6'd1,  1'b1, 5'd15}, {6'd15, 1'b1, 5'd1},  {6'd32, 1'b1, 5'd31},
    {6'd47, 1'b1, 5'd16}, {6'd16, 1'b0, 5'd2},  {6'd18, 1'b0, 5'd0},
    {6'd19, 1'b0, 5'd14}, {6'd30, 1'b0, 5'd3},  {6'd31, 1'b0, 5'd0},
    {6'd48, 1'b0, 5'd16}, {6'd63, 1'b0, 5'd31}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(4);
    rst = 1'b0;
    tick(6);

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    for (int a = 0; a < 9; a++) rd_chk("R1 reg", 4'(a), 32'd0);
    // R12 unmapped address
    rd_chk("R12 unmapped", 4'd15, 32'd0);

    // R4 mask readback, including an unused low bit
    wr(4'd1, 32'hFFFF_FFFF);
    rd_chk("R4 mask lo readback", 4'd1, 32'hFFFF_FFFF);
    wr(4'd0, 32'h1234_5678);
    rd_chk("R4 mask hi readback", 4'd0, 32'h1234_5678);
    wr(4'd0, 32'd0);
    wr(4'd1, 32'd0);

    // R2 / R3 mapping table, rising-edge pulses
    foreach (MAP_TBL[i]) begin
      int v;
      logic hi;
      logic [4:0] b;
      v  = int'(MAP_TBL[i][11:6]);
      hi = MAP_TBL[i][5];
      b  = MAP_TBL[i][4:0];
      wr(4'(5 + v / 16), 32'd3 << (2 * (v % 16)));
      wr(hi ? 4'd0 : 4'd1, 32'd1 << b);
      src_i[v] = 1'b0; tick(5);
      src_i[v] = 1'b1; tick(6);
      rd_chk(hi ? "R2 pend own reg" : "R3 pend own reg", hi ? 4'd2 : 4'd3, 32'd1 << b);
      rd_chk(hi ? "R2 pend other reg" : "R3 pend other reg", hi ? 4'd3 : 4'd2, 32'd0);
      rd_chk("R6 vector field", 4'd4, 32'(v) << 26);
      chk("R6 irq high", {31'd0, irq_o}, 32'd1);
      wr(hi ? 4'd2 : 4'd3, 32'd1 << b);
      tick(2);
      chk("R5 irq low after clear", {31'd0, irq_o}, 32'd0);
      rd_chk("R6 vector none", 4'd4, 32'd0);
      wr(4'(5 + v / 16), 32'd0);
      wr(hi ? 4'd0 : 4'd1, 32'd0);
    end

    // R7 priority: sources 5 (hi bit 11) and 40 (hi bit 23)
    wr(4'd5, 32'd3 << 10);
    wr(4'd7, 32'd3 << 16);
    wr(4'd0, 32'hFFFF_FFFF);
    src_i[5] = 1'b0; src_i[40] = 1'b0; tick(5);
    src_i[5] = 1'b1; src_i[40] = 1'b1; tick(6);
    rd_chk("R7 both pending", 4'd2, (32'd1 << 11) | (32'd1 << 23));
    rd_chk("R7 lowest wins", 4'd4, 32'd5 << 26);
    wr(4'd2, 32'd0);
    tick(2);
    rd_chk("R5 write zero no effect", 4'd2, (32'd1 << 11) | (32'd1 << 23));
    wr(4'd2, 32'd1 << 11);
    tick(2);
    rd_chk("R7 next source", 4'd4, 32'd40 << 26);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
    tick(2);
    rd_chk("R5 clear all", 4'd2, 32'd0);

    // R4 masked pending still visible, no request
    wr(4'd0, 32'd0);
    src_i[5] = 1'b0; tick(5);
    src_i[5] = 1'b1; tick(6);
    chk("R4 masked no irq", {31'd0, irq_o}, 32'd0);
    rd_chk("R4 masked vector", 4'd4, 32'd0);
    rd_chk("R4 masked pend visible", 4'd2, 32'd1 << 11);
    wr(4'd0, 32'd1 << 11);
    tick(2);
    chk("R4 unmask raises irq", {31'd0, irq_o}, 32'd1);
    wr(4'd2, 32'd1 << 11);
    wr(4'd0, 32'd0);

    // R10 falling edge on source 10 (hi bit 6)
    wr(4'd5, 32'd2 << 20);
    wr(4'd0, 32'd1 << 6);
    src_i[10] = 1'b0; tick(6);
    rd_chk("R10 falling sets", 4'd2, 32'd1 << 6);
    wr(4'd2, 32'd1 << 6);
    src_i[10] = 1'b1; tick(6);
    rd_chk("R10 rising ignored", 4'd2, 32'd0);
    chk("R10 irq stays low", {31'd0, irq_o}, 32'd0);
    wr(4'd5, 32'd0);

    // R11 source 0 with level-low sense and bit 0 unmasked
    wr(4'd0, 32'hFFFF_FFFF);
    src_i[0] = 1'b0; tick(8);
    rd_chk("R11 src0 no pend", 4'd2, 32'd0);
    chk("R11 src0 no irq", {31'd0, irq_o}, 32'd0);
    src_i[0] = 1'b1;
    wr(4'd0, 32'd0);

    // R9 level low on source 50 (lo bit 18)
    wr(4'd1, 32'd1 << 18);
    src_i[50] = 1'b0; tick(6);
    rd_chk("R9 level low vector", 4'd4, 32'd50 << 26);
    wr(4'd3, 32'd1 << 18);
    tick(2);
    rd_chk("R9 clear overridden", 4'd3, 32'd1 << 18);
    src_i[50] = 1'b1; tick(6);
    rd_chk("R9 held after release", 4'd3, 32'd1 << 18);
    wr(4'd3, 32'd1 << 18);
    tick(2);
    chk("R9 cleared irq low", {31'd0, irq_o}, 32'd0);
    wr(4'd1, 32'd0);

    // R9 level high on source 20 (lo bit 13)
    src_i[20] = 1'b0; tick(6);
    wr(4'd6, 32'd1 << 8);
    wr(4'd3, 32'hFFFF_FFFF);
    tick(2);
    rd_chk("R9 level high inactive", 4'd3, 32'd0);
    wr(4'd1, 32'd1 << 13);
    src_i[20] = 1'b1; tick(6);
    rd_chk("R9 level high sets", 4'd3, 32'd1 << 13);
    rd_chk("R9 level high vector", 4'd4, 32'd20 << 26);
    src_i[20] = 1'b0; tick(6);
    wr(4'd3, 32'd1 << 13);
    tick(2);
    rd_chk("R9 cleared once inactive", 4'd3, 32'd0);
    wr(4'd1, 32'd0);

    // R8 sense readback
    wr(4'd8, 32'hA5C3_0F96);
    rd_chk("R8 sense readback", 4'd8, 32'hA5C3_0F96);
    rd_chk("R8 other sense word", 4'd6, 32'd1 << 8);
    d = 32'd0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule